// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog that software can address as memory. It holds a 32-bit counter that counts up. The counter is advanced by a slow tick enable, nominally 32.768 kHz, and an optional power-of-two divider sits in front of it. When the counter steps past its all-ones value, the block issues a one-cycle expiry pulse, which is meant to reset the system. The counter then continues from the value in the load register.

Software cannot stop or start the timer by accident. A start needs two writes to the run-control register: 0xBBBB followed by 0x4444. A stop needs 0xAAAA followed by 0x5555. To keep the timer alive, software writes a new value to the trigger register, which copies the load value into the counter. Software can also write the counter directly, for example to force an early expiry.

Every write to a control register is posted. It takes effect a fixed number of core cycles after the bus write, as a crossing into a slow clock domain would. While a write is still in flight, its pending flag reads 1.

Top module: `wdt_keyed`

## Requirements
- R1: After reset, expire is low, and the control, counter, load, trigger and pending-status registers all read 0. The timer is running, so the counter advances on ticks without any start sequence.
- R2: A read of word offset 0x00 returns a constant, with the major revision in bits 7:4 and the minor revision in bits 3:0 (default 0x10). A read of an offset that no register uses returns 0.
- R3: The pending-status register is at 0x34. Its bits are: bit 0 for control (0x24), bit 1 for counter (0x28), bit 2 for load (0x2C), bit 3 for trigger (0x30) and bit 4 for run-control (0x48). A write to one of these registers sets its bit from the next cycle on. The written value takes effect exactly POST_CYC cycles after the write edge, and the pending bit clears on that same edge.
- R4: A run-control write of 0xBBBB, followed by a run-control write of 0x4444 as the next such write, starts the timer.
- R5: A run-control write of 0xAAAA, followed by 0x5555 as the next such write, stops the timer. A stopped counter holds its value while ticks arrive.
- R6: A run-control write that does not complete a key pair discards any first half already seen, and leaves the running state unchanged.
- R7: A trigger write whose value differs from the current trigger contents stores that value and loads the counter from the load register. A trigger write whose value equals the current contents changes nothing.
- R8: While the timer runs with control bit 5 clear, the counter steps by 1 per tick. With bit 5 set, bits 4:2 hold k, and the counter steps once per 2^k ticks.
- R9: When the counter steps from 0xFFFFFFFF, expire is high for exactly one cycle and the counter takes the load value.
- R10: A write to the counter register replaces the count once the posting delay has passed. This write wins over a trigger reload that takes effect in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_32k | input | 1 | Counter tick enable, one core cycle per tick |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; data is returned on the next cycle |
| bus_addr | input | AW | Byte address; the low two bits are ignored |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| expire | output | 1 | One-cycle timeout pulse |

## Verification
Expiry is the hardest case to reach. From reset it needs 2^32 ticks, which is far out of reach for a bench. The stimulus first posts a load value and then posts a counter value of 0xFFFFFFFE. It then gives exactly two ticks, which makes the wrap happen on a known edge. The bench then checks the pulse count, the pulse width and the reloaded count. The exact clearing edge of a pending flag is hit by issuing status reads back to back, one per cycle, straight after a posted write.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int NSLOT     = 5;
  localparam int SLOT_CTRL = 0;
  localparam int SLOT_CNT  = 1;
  localparam int SLOT_LOAD = 2;
  localparam int SLOT_TRIG = 3;
  localparam int SLOT_RUN  = 4;

  localparam logic [7:0] OFS_ID   = 8'h00;
  localparam logic [7:0] OFS_CTRL = 8'h24;
  localparam logic [7:0] OFS_CNT  = 8'h28;
  localparam logic [7:0] OFS_LOAD = 8'h2C;
  localparam logic [7:0] OFS_TRIG = 8'h30;
  localparam logic [7:0] OFS_PEND = 8'h34;
  localparam logic [7:0] OFS_RUN  = 8'h48;

  localparam logic [31:0] KEY_START_A = 32'h0000_BBBB;
  localparam logic [31:0] KEY_START_B = 32'h0000_4444;
  localparam logic [31:0] KEY_STOP_A  = 32'h0000_AAAA;
  localparam logic [31:0] KEY_STOP_B  = 32'h0000_5555;

  typedef enum logic [1:0] {
    KS_IDLE  = 2'd0,
    KS_START = 2'd1,
    KS_STOP  = 2'd2
  } key_state_e;

  function automatic logic [7:0] slot_ofs(input int idx);
    case (idx)
      SLOT_CTRL: slot_ofs = OFS_CTRL;
      SLOT_CNT:  slot_ofs = OFS_CNT;
      SLOT_LOAD: slot_ofs = OFS_LOAD;
      SLOT_TRIG: slot_ofs = OFS_TRIG;
      default:   slot_ofs = OFS_RUN;
    endcase
  endfunction

endpackage

// File: rtl/wdt_post.sv
module wdt_post #(
  parameter int DW    = 32,
  parameter int DELAY = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_hit,
  input  logic [DW-1:0] wr_data,
  output logic          pend,
  output logic          fire,
  output logic [DW-1:0] fire_data
);
  localparam int LW = (DELAY < 2) ? 1 : $clog2(DELAY);

  logic [LW-1:0] left;
  logic [DW-1:0] held;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      left <= '0;
      held <= '0;
    end else if (wr_hit) begin
      pend <= 1'b1;
      left <= LW'(DELAY - 1);
      held <= wr_data;
    end else if (pend) begin
      if (left == '0) pend <= 1'b0;
      else            left <= left - 1'b1;
    end
  end

  assign fire      = pend && (left == '0);
  assign fire_data = held;

  // R3: a bus write marks the register as pending on the next cycle
  p_wr_sets_pend_r3: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> pend);
  // R3: an applied write with no new write behind it clears pending
  p_fire_clears_r3: assert property (@(posedge clk) disable iff (rst)
    (fire && !wr_hit) |=> !pend);

endmodule

// File: rtl/wdt_keyseq.sv
module wdt_keyseq
  import wdt_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          apply,
  input  logic [DW-1:0] word,
  output logic          running
);
  key_state_e state;
  logic hit_start, hit_stop;

  assign hit_start = (state == KS_START) && (word == DW'(KEY_START_B));
  assign hit_stop  = (state == KS_STOP)  && (word == DW'(KEY_STOP_B));

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= KS_IDLE;
      running <= 1'b1;
    end else if (apply) begin
      if (hit_start) begin
        running <= 1'b1;
        state   <= KS_IDLE;
      end else if (hit_stop) begin
        running <= 1'b0;
        state   <= KS_IDLE;
      end else if (word == DW'(KEY_START_A)) begin
        state <= KS_START;
      end else if (word == DW'(KEY_STOP_A)) begin
        state <= KS_STOP;
      end else begin
        state <= KS_IDLE;
      end
    end
  end

  // R4: a completed start pair leaves the timer running
  p_start_pair_r4: assert property (@(posedge clk) disable iff (rst)
    (apply && hit_start) |=> running);
  // R5: a completed stop pair leaves the timer stopped
  p_stop_pair_r5: assert property (@(posedge clk) disable iff (rst)
    (apply && hit_stop) |=> !running);
  // R6: any other run-control word keeps the running state
  p_no_change_r6: assert property (@(posedge clk) disable iff (rst)
    (apply && !hit_start && !hit_stop) |=> (running == $past(running)));

endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int CW = 32,
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          running,
  input  logic          pre_en,
  input  logic [PW-1:0] ratio,
  input  logic          ld_en,
  input  logic [CW-1:0] ld_val,
  input  logic [CW-1:0] reload_val,
  output logic [CW-1:0] cnt,
  output logic          wrap_pulse
);
  localparam int PCW = (1 << PW) - 1;

  logic [PCW:0] presc;
  logic [PCW:0] span;
  logic         step;

  assign span = ((PCW + 1)'(1) << ratio) - (PCW + 1)'(1);
  assign step = tick && (!pre_en || (presc == span));

  always_ff @(posedge clk) begin
    if (rst || !pre_en) begin
      presc <= '0;
    end else if (tick && running) begin
      presc <= (presc == span) ? '0 : presc + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      wrap_pulse <= 1'b0;
    end else begin
      wrap_pulse <= 1'b0;
      if (ld_en) begin
        cnt <= ld_val;
      end else if (running && step) begin
        if (cnt == '1) begin
          cnt        <= reload_val;
          wrap_pulse <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R5: with the timer stopped and no load, the count stays put
  p_stop_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!running && !ld_en) |=> $stable(cnt));
  // R8: a counting step adds exactly one below the top value
  p_step_one_r8: assert property (@(posedge clk) disable iff (rst)
    (running && step && !ld_en && cnt != '1) |=> (cnt == $past(cnt) + 1'b1));
  // R9: stepping from all ones raises the expiry pulse
  p_wrap_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    (running && step && !ld_en && cnt == '1) |=> wrap_pulse);

endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
  import wdt_pkg::*;
#(
  parameter int         AW       = 8,
  parameter int         DW       = 32,
  parameter int         POST_CYC = 4,
  parameter int         PRE_W    = 3,
  parameter logic [3:0] ID_MAJOR = 4'h1,
  parameter logic [3:0] ID_MINOR = 4'h0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_32k,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          expire
);
  localparam logic [DW-1:0] CTRL_MASK = DW'(((1 << (PRE_W + 1)) - 1) << 2);

  logic [AW-1:0]    word_addr;
  logic [NSLOT-1:0] wr_sel, pend, fire;
  logic [DW-1:0]    fdata [NSLOT];

  logic [DW-1:0] ctrl_q, load_q, trig_q, run_q, cnt;
  logic          running, trig_reload, ld_en;
  logic [DW-1:0] ld_val;

  assign word_addr = bus_addr & ~AW'(3);

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    assign wr_sel[i] = bus_wr && (word_addr == AW'(slot_ofs(i)));
    wdt_post #(.DW(DW), .DELAY(POST_CYC)) u_post (
      .clk      (clk),
      .rst      (rst),
      .wr_hit   (wr_sel[i]),
      .wr_data  (bus_wdata),
      .pend     (pend[i]),
      .fire     (fire[i]),
      .fire_data(fdata[i])
    );
  end

  assign trig_reload = fire[SLOT_TRIG] && (fdata[SLOT_TRIG] != trig_q);
  assign ld_en       = fire[SLOT_CNT] || trig_reload;
  assign ld_val      = fire[SLOT_CNT] ? fdata[SLOT_CNT] : load_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      load_q <= '0;
      trig_q <= '0;
      run_q  <= '0;
    end else begin
      if (fire[SLOT_CTRL]) ctrl_q <= fdata[SLOT_CTRL] & CTRL_MASK;
      if (fire[SLOT_LOAD]) load_q <= fdata[SLOT_LOAD];
      if (trig_reload)     trig_q <= fdata[SLOT_TRIG];
      if (fire[SLOT_RUN])  run_q  <= fdata[SLOT_RUN];
    end
  end

  wdt_keyseq #(.DW(DW)) u_keys (
    .clk    (clk),
    .rst    (rst),
    .apply  (fire[SLOT_RUN]),
    .word   (fdata[SLOT_RUN]),
    .running(running)
  );

  wdt_count #(.CW(DW), .PW(PRE_W)) u_count (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick_32k),
    .running   (running),
    .pre_en    (ctrl_q[2 + PRE_W]),
    .ratio     (ctrl_q[2 +: PRE_W]),
    .ld_en     (ld_en),
    .ld_val    (ld_val),
    .reload_val(load_q),
    .cnt       (cnt),
    .wrap_pulse(expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (word_addr)
        AW'(OFS_ID):   bus_rdata <= DW'({ID_MAJOR, ID_MINOR});
        AW'(OFS_CTRL): bus_rdata <= ctrl_q;
        AW'(OFS_CNT):  bus_rdata <= cnt;
        AW'(OFS_LOAD): bus_rdata <= load_q;
        AW'(OFS_TRIG): bus_rdata <= trig_q;
        AW'(OFS_PEND): bus_rdata <= DW'(pend);
        AW'(OFS_RUN):  bus_rdata <= run_q;
        default:       bus_rdata <= '0;
      endcase
    end
  end

  // R9: the expiry output never lasts two cycles
  p_single_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    expire |=> !expire);
  // R7: a trigger write of a new value reloads the count from load
  p_trig_reload_r7: assert property (@(posedge clk) disable iff (rst)
    (trig_reload && !fire[SLOT_CNT]) |=> (cnt == $past(load_q)));
  // R7: a trigger write of the same value leaves the trigger register alone
  p_trig_same_r7: assert property (@(posedge clk) disable iff (rst)
    (fire[SLOT_TRIG] && fdata[SLOT_TRIG] == trig_q) |=> $stable(trig_q));
  // R10: a direct counter write wins over everything else
  p_cnt_write_r10: assert property (@(posedge clk) disable iff (rst)
    fire[SLOT_CNT] |=> (cnt == $past(fdata[SLOT_CNT])));

endmodule

// File: tb/wdt_keyed_bench.sv
module wdt_keyed_bench;
  localparam int POST = 4;
  localparam logic [7:0] A_ID = 8'h00, A_CTRL = 8'h24, A_CNT = 8'h28,
    A_LOAD = 8'h2C, A_TRIG = 8'h30, A_PEND = 8'h34, A_RUN = 8'h48;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_32k = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        expire;

  int total = 0;
  int bad = 0;
  int pulses = 0;
  int run_len = 0;
  int max_run = 0;
  logic rd_seen = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  wdt_keyed #(.POST_CYC(POST)) u_wdt_keyed (
    .clk(clk), .rst(rst), .tick_32k(tick_32k),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .expire(expire)
  );

  always @(posedge clk) rd_seen <= bus_rd;

  // monitor: compares each returned read word with the scoreboard
  always @(negedge clk) begin
    if (rd_seen) begin
      logic [31:0] e;
      string t;
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL scoreboard underrun: got %h", bus_rdata);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          bad++;
          $display("FAIL %s: got %h expected %h", t, bus_rdata, e);
        end
      end
    end
    if (expire) begin
      pulses++;
      run_len++;
      if (run_len > max_run) max_run = run_len;
    end else begin
      run_len = 0;
    end
  end

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr_np(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_np(a, d);
    repeat (POST) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    tick_32k = 1'b1;
    repeat (n) @(negedge clk);
    tick_32k = 1'b0;
  endtask

  task automatic chk(input bit ok, input string t, input int got, input int e);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", t, got, e);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(expire == 1'b0, "R1 expire low", int'(expire), 0);
    rd(A_CNT, 32'h0, "R1 counter");
    rd(A_LOAD, 32'h0, "R1 load");
    rd(A_CTRL, 32'h0, "R1 control");
    rd(A_TRIG, 32'h0, "R1 trigger");
    rd(A_PEND, 32'h0, "R1 pending");
    // R2 identification and unused offsets
    rd(A_ID, 32'h10, "R2 id");
    rd(8'h04, 32'h0, "R2 unused 0x04");
    rd(8'h40, 32'h0, "R2 unused 0x40");
    // R3 exact posting window
    wr_np(A_LOAD, 32'h1234);
    rd(A_PEND, 32'h4, "R3 pend E1");
    rd(A_PEND, 32'h4, "R3 pend E2");
    rd(A_PEND, 32'h4, "R3 pend E3");
    rd(A_PEND, 32'h4, "R3 pend apply edge");
    rd(A_PEND, 32'h0, "R3 pend cleared");
    rd(A_LOAD, 32'h1234, "R3 load applied");
    // R3 two slots in flight, R10 direct counter write
    wr_np(A_CTRL, 32'h0);
    wr_np(A_CNT, 32'h100);
    rd(A_PEND, 32'h3, "R3 ctrl+cnt pending");
    repeat (POST) @(negedge clk);
    rd(A_PEND, 32'h0, "R3 both cleared");
    rd(A_CNT, 32'h100, "R10 counter write");
    // R1/R8 runs from reset, one step per tick
    ticks(10);
    rd(A_CNT, 32'h10A, "R8 ten ticks");
    // R8 prescaler divide by 4
    wr(A_CTRL, 32'h28);
    rd(A_CTRL, 32'h28, "R8 control readback");
    ticks(12);
    rd(A_CNT, 32'h10D, "R8 prescaled by 4");
    wr(A_CTRL, 32'h0);
    // R5 stop
    wr(A_RUN, 32'hAAAA);
    wr(A_RUN, 32'h5555);
    ticks(10);
    rd(A_CNT, 32'h10D, "R5 stopped holds");
    // R6 broken start pair
    wr(A_RUN, 32'hBBBB);
    wr(A_RUN, 32'h1234);
    wr(A_RUN, 32'h4444);
    ticks(5);
    rd(A_CNT, 32'h10D, "R6 broken start stays stopped");
    // R4 start
    wr(A_RUN, 32'hBBBB);
    wr(A_RUN, 32'h4444);
    ticks(5);
    rd(A_CNT, 32'h112, "R4 started counts");
    // R6 broken stop pair
    wr(A_RUN, 32'hAAAA);
    wr(A_RUN, 32'h0001);
    wr(A_RUN, 32'h5555);
    ticks(5);
    rd(A_CNT, 32'h117, "R6 broken stop keeps running");
    rd(A_RUN, 32'h5555, "R6 run-control readback");
    // R7 trigger
    wr(A_LOAD, 32'hABC);
    wr_np(A_TRIG, 32'h0);
    rd(A_PEND, 32'h8, "R3 trigger pending");
    repeat (POST - 1) @(negedge clk);
    rd(A_CNT, 32'h117, "R7 same value no reload");
    wr(A_TRIG, 32'h5);
    rd(A_CNT, 32'hABC, "R7 new value reloads");
    wr(A_CNT, 32'h77);
    wr(A_TRIG, 32'h5);
    rd(A_CNT, 32'h77, "R7 repeat value no reload");
    rd(A_TRIG, 32'h5, "R7 trigger readback");
    // R9 wrap and expiry
    wr(A_LOAD, 32'h10);
    wr(A_CNT, 32'hFFFF_FFFE);
    chk(pulses == 0, "R9 no early expiry", pulses, 0);
    ticks(2);
    rd(A_CNT, 32'h10, "R9 reload after wrap");
    chk(pulses == 1, "R9 one expiry", pulses, 1);
    chk(max_run == 1, "R9 pulse width", max_run, 1);
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule